// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This combinational unit sits in the execute path of a 16-bit processor and resolves the short-displacement branch group. It looks at the fetched instruction word and recognises whether it belongs to the branch format. The upper byte of the word selects the condition and the lower byte holds a signed word displacement. If it is a branch, the unit evaluates the condition against the N, Z, V and C flags left by the previous instruction. It also forms the destination address from the already-advanced program counter.

The conditions fall into four families. The first is the unconditional branch. The second is the single-flag tests on Z, N, V and C, each in both polarities. The third is the signed comparisons, built from N, V and Z. The fourth is the unsigned comparisons, built from C and Z. The unsigned "higher or same" and "lower" tests are not separate encodings: they are the carry-clear and carry-set codes. Jumps, subroutine linkage, traps and the counted loop instruction are decoded elsewhere and are never flagged here.

The unit has no state, so it has no state machine and no reset. The decode, condition and address pieces are separate modules joined by a package-level condition enumeration.

Top module: `bdu_branch_unit`

## Requirements
- R1: `is_branch` is 1 exactly when instruction bits 14:11 are all zero and either bit 15 is 1 or bits 10:8 are nonzero. The condition is selected by {bit 15, bits 10:8}. For bit 15 = 0, codes 1..7 are always, not-equal, equal, greater-or-equal, less-than, greater-than and less-or-equal. For bit 15 = 1, codes 0..7 are plus, minus, higher, lower-or-same, overflow-clear, overflow-set, carry-clear and carry-set.
- R2: A word whose upper byte is zero is never reported as a branch, whatever its lower byte holds.
- R3: The always code (upper byte 0x01) is taken for all 16 flag combinations.
- R4: Not-equal is taken when Z = 0, and equal is taken when Z = 1.
- R5: Plus is taken when N = 0, and minus is taken when N = 1.
- R6: Overflow-clear is taken when V = 0, and overflow-set is taken when V = 1.
- R7: Carry-clear (also used as unsigned higher-or-same) is taken when C = 0. Carry-set (also used as unsigned lower) is taken when C = 1.
- R8: Greater-or-equal is taken when N^V = 0, and less-than is taken when N^V = 1. Greater-than is taken when Z|(N^V) = 0, and less-or-equal is taken when Z|(N^V) = 1.
- R9: Higher is taken when C = 0 and Z = 0, and lower-or-same is taken when C|Z = 1.
- R10: `target` equals `pc_next` plus twice the sign-extended bits 7:0. Offset 0x7F gives +254 and offset 0x80 gives −256.
- R11: `taken` is 0 whenever `is_branch` is 0.
- R12: `target` wraps modulo 2^16, and its bit 0 always equals `pc_next` bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 16 | Instruction word under execution |
| pc_next | input | 16 | Program counter already advanced past the instruction |
| flag_n | input | 1 | Negative flag from the previous instruction |
| flag_z | input | 1 | Zero flag from the previous instruction |
| flag_v | input | 1 | Overflow flag from the previous instruction |
| flag_c | input | 1 | Carry flag from the previous instruction |
| is_branch | output | 1 | Word is a branch-format instruction |
| taken | output | 1 | Branch condition holds |
| target | output | 16 | Destination address |

## Verification
The bench sweeps every upper-byte value against every flag combination, so that each condition meets each of the 16 flag patterns. A swapped polarity or a wrong flag would then show up as a mistaken taken decision. Words whose upper byte is zero or has bits 14:11 set are aimed at the decode: a design that checked only bit 15 or bits 10:8 would claim halts, traps or jumps as branches. Offsets 0x7F and 0x80 and program counters near the top of memory catch zero-extension, a missing doubling and a lost carry in the target adder.

// File: rtl/bdu_pkg.sv
package bdu_pkg;

    localparam int INSTR_W = 16;
    localparam int OFS_W   = 8;

    typedef enum logic [3:0] {
        BC_NONE,
        BC_ALWAYS,
        BC_NE,
        BC_EQ,
        BC_GE,
        BC_LT,
        BC_GT,
        BC_LE,
        BC_PL,
        BC_MI,
        BC_HI,
        BC_LOS,
        BC_VC,
        BC_VS,
        BC_CC,
        BC_CS
    } bcond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

endpackage

// File: rtl/bdu_decode.sv
module bdu_decode
    import bdu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output bcond_e             cond,
    output logic               is_branch
);
    // Bits that must be zero for the branch group to apply.
    localparam int GAP_HI = INSTR_W - 2;
    localparam int GAP_LO = OFS_W + 3;

    logic       top_bit;
    logic [2:0] sel;
    logic       gap_clear;

    assign top_bit   = instr[INSTR_W-1];
    assign sel       = instr[OFS_W+2:OFS_W];
    assign gap_clear = (instr[GAP_HI:GAP_LO] == '0);

    always_comb begin
        cond = BC_NONE;
        if (gap_clear) begin
            unique case ({top_bit, sel})
                4'b0_000: cond = BC_NONE;
                4'b0_001: cond = BC_ALWAYS;
                4'b0_010: cond = BC_NE;
                4'b0_011: cond = BC_EQ;
                4'b0_100: cond = BC_GE;
                4'b0_101: cond = BC_LT;
                4'b0_110: cond = BC_GT;
                4'b0_111: cond = BC_LE;
                4'b1_000: cond = BC_PL;
                4'b1_001: cond = BC_MI;
                4'b1_010: cond = BC_HI;
                4'b1_011: cond = BC_LOS;
                4'b1_100: cond = BC_VC;
                4'b1_101: cond = BC_VS;
                4'b1_110: cond = BC_CC;
                4'b1_111: cond = BC_CS;
                default:  cond = BC_NONE;
            endcase
        end
    end

    assign is_branch = (cond != BC_NONE);

    // R2: an all-zero upper byte must never decode as a branch
    always_comb begin
        if (!$isunknown(instr)) begin
            p_zero_byte_not_branch_r2: assert (!(instr[INSTR_W-1:OFS_W] == '0 && is_branch))
                else $error("zero upper byte decoded as branch");
        end
    end

endmodule

// File: rtl/bdu_cond_eval.sv
module bdu_cond_eval
    import bdu_pkg::*;
(
    input  bcond_e cond,
    input  flags_t flags,
    output logic   holds
);
    logic sgn_lt;
    logic sgn_le;
    logic uns_le;

    assign sgn_lt = flags.n ^ flags.v;
    assign sgn_le = flags.z | sgn_lt;
    assign uns_le = flags.c | flags.z;

    always_comb begin
        unique case (cond)
            BC_NONE:   holds = 1'b0;
            BC_ALWAYS: holds = 1'b1;
            BC_NE:     holds = ~flags.z;
            BC_EQ:     holds =  flags.z;
            BC_GE:     holds = ~sgn_lt;
            BC_LT:     holds =  sgn_lt;
            BC_GT:     holds = ~sgn_le;
            BC_LE:     holds =  sgn_le;
            BC_PL:     holds = ~flags.n;
            BC_MI:     holds =  flags.n;
            BC_HI:     holds = ~uns_le;
            BC_LOS:    holds =  uns_le;
            BC_VC:     holds = ~flags.v;
            BC_VS:     holds =  flags.v;
            BC_CC:     holds = ~flags.c;
            BC_CS:     holds =  flags.c;
            default:   holds = 1'b0;
        endcase
    end

    // R9: higher is never taken with a zero result
    always_comb begin
        if (!$isunknown({cond, flags})) begin
            p_hi_blocked_by_zero_r9: assert (!(cond == BC_HI && flags.z && holds))
                else $error("higher taken with Z set");
            // R8: greater-than never taken with a zero result
            p_gt_blocked_by_zero_r8: assert (!(cond == BC_GT && flags.z && holds))
                else $error("greater-than taken with Z set");
        end
    end

endmodule

// File: rtl/bdu_target.sv
module bdu_target
    import bdu_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] pc_next,
    input  logic [OFS_W-1:0]  offset,
    output logic [ADDR_W-1:0] target
);
    localparam int EXT_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] disp;

    assign disp   = {{(EXT_W-1){offset[OFS_W-1]}}, offset, 1'b0};
    assign target = pc_next + disp;

    // R12: doubling keeps the low address bit of the advanced PC
    always_comb begin
        if (!$isunknown({pc_next, offset})) begin
            p_parity_kept_r12: assert (target[0] == pc_next[0])
                else $error("target parity differs from pc_next");
        end
    end

endmodule

// File: rtl/bdu_branch_unit.sv
module bdu_branch_unit
    import bdu_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [ADDR_W-1:0]  pc_next,
    input  logic               flag_n,
    input  logic               flag_z,
    input  logic               flag_v,
    input  logic               flag_c,
    output logic               is_branch,
    output logic               taken,
    output logic [ADDR_W-1:0]  target
);
    bcond_e cond;
    flags_t flags;
    logic   holds;

    assign flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

    bdu_decode u_decode (
        .instr     (instr),
        .cond      (cond),
        .is_branch (is_branch)
    );

    bdu_cond_eval u_eval (
        .cond  (cond),
        .flags (flags),
        .holds (holds)
    );

    bdu_target #(.ADDR_W(ADDR_W)) u_target (
        .pc_next (pc_next),
        .offset  (instr[OFS_W-1:0]),
        .target  (target)
    );

    assign taken = holds;

    always_comb begin
        if (!$isunknown({instr, flags})) begin
            // R11: never taken outside the branch group
            p_taken_implies_branch_r11: assert (!(taken && !is_branch))
                else $error("taken without branch");
            // R3: unconditional code always taken
            p_always_taken_r3: assert (!(instr[INSTR_W-1:OFS_W] == 8'h01 && !taken))
                else $error("unconditional branch not taken");
        end
    end

endmodule

// File: tb/bdu_branch_unit_bench.sv
module bdu_branch_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr = '0;
    logic [15:0] pc_next = '0;
    logic        flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
    logic        is_branch, taken;
    logic [15:0] target;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bdu_branch_unit u_bdu_branch_unit (
        .instr, .pc_next, .flag_n, .flag_z, .flag_v, .flag_c,
        .is_branch, .taken, .target
    );

    // Behavioural reference, from octal base codes.
    function automatic bit ref_br(input logic [15:0] w);
        logic [15:0] b = w & 16'o177400;
        return b inside {16'o000400, 16'o001000, 16'o001400, 16'o002000, 16'o002400,
                         16'o003000, 16'o003400, 16'o100000, 16'o100400, 16'o101000,
                         16'o101400, 16'o102000, 16'o102400, 16'o103000, 16'o103400};
    endfunction

    function automatic bit ref_tk(input logic [15:0] w, input bit n, z, v, c);
        case (w & 16'o177400)
            16'o000400: return 1;
            16'o001000: return !z;
            16'o001400: return z;
            16'o002000: return (n == v);
            16'o002400: return (n != v);
            16'o003000: return !z && (n == v);
            16'o003400: return z || (n != v);
            16'o100000: return !n;
            16'o100400: return n;
            16'o101000: return !c && !z;
            16'o101400: return c || z;
            16'o102000: return !v;
            16'o102400: return v;
            16'o103000: return !c;
            16'o103400: return c;
            default:    return 0;
        endcase
    endfunction

    function automatic string tag_of(input logic [15:0] w);
        case (w & 16'o177400)
            16'o000400:             return "R3";
            16'o001000, 16'o001400: return "R4";
            16'o100000, 16'o100400: return "R5";
            16'o102000, 16'o102400: return "R6";
            16'o103000, 16'o103400: return "R7";
            16'o101000, 16'o101400: return "R9";
            16'o002000, 16'o002400,
            16'o003000, 16'o003400: return "R8";
            default:                return "R11";
        endcase
    endfunction

    task automatic apply(input logic [15:0] w, input logic [15:0] pc, input logic [3:0] f);
        @(posedge clk);
        instr = w; pc_next = pc;
        {flag_n, flag_z, flag_v, flag_c} = f;
        @(negedge clk);
        begin
            bit          eb = ref_br(w);
            bit          et = ref_tk(w, f[3], f[2], f[1], f[0]);
            int          so = $signed(w[7:0]);
            logic [15:0] ea = pc + 16'(so * 2);
            n_vec++;
            if (is_branch !== eb) begin
                n_fail++;
                $display("FAIL %s is_branch instr=%o got %b exp %b",
                         (w[15:8] == 8'h00) ? "R2" : "R1", w, is_branch, eb);
            end
            if (taken !== et) begin
                n_fail++;
                $display("FAIL %s taken instr=%o f=%b got %b exp %b", tag_of(w), w, f, taken, et);
            end
            if (target !== ea) begin
                n_fail++;
                $display("FAIL %s target instr=%o pc=%h got %h exp %h",
                         (pc > 16'hFE00) ? "R12" : "R10", w, pc, target, ea);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset state: zero word is not a branch, nothing taken (R2)
        @(negedge clk);
        n_vec++;
        if (is_branch !== 1'b0 || taken !== 1'b0) begin
            n_fail++;
            $display("FAIL R2 reset-state got %b%b exp 00", is_branch, taken);
        end
        // Every upper byte against every flag pattern (R1, R3-R9, R11)
        for (int op = 0; op < 256; op++) begin
            for (int f = 0; f < 16; f++) begin
                apply({8'(op), 8'((op * 7 + f * 29) & 8'hFF)}, 16'((op * 517 + f * 62) & 16'hFFFE), 4'(f));
            end
        end
        // Zero upper byte with all low bytes (R2)
        for (int lo = 0; lo < 256; lo++) apply({8'h00, 8'(lo)}, 16'h1000, 4'hF);
        // Offset extremes (R10)
        apply(16'o000577, 16'h2000, 4'h0);
        apply(16'o000600, 16'h2000, 4'h0);
        apply(16'o000400, 16'h2000, 4'h0);
        // Wrap-around and odd PC parity (R12)
        apply(16'o000577, 16'hFFFE, 4'h0);
        apply(16'o000600, 16'h0010, 4'h0);
        apply(16'o001177, 16'hFF81, 4'h0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule